// File: doc/BRIEF.md
# Zero-Pad Input Rate Adapter

This block sits at the head of a downconverter channel whose datapath consumes one sample on every clock. Real input data may arrive more slowly than the clock. When padding is switched on, the adapter takes one input sample and then emits a programmed number of zero-valued slots after it. Downstream logic therefore still sees one value per clock, and the real data is spread out at a fixed spacing. When padding is switched off, every clock carries an input sample straight through.

A single control word sets the behaviour. It holds an enable bit and a 4-bit zero count. A strobe marks every output slot that carries real data, so later stages can tell data from padding.

Internally a three-state sequencer decides which clocks take an input sample:

- PASS: padding is off, and a sample is taken every clock.
- TAKE: padding is on, and a sample is taken in this slot.
- PAD: a zero is emitted while a 4-bit down counter runs out.

The transitions are:

- PASS→TAKE or PASS→PAD when the enable bit is seen.
- TAKE→TAKE when the count is zero.
- TAKE→PAD when the count is non-zero.
- TAKE→PASS when the enable bit has been cleared.
- PAD→PAD while the counter is above one.
- PAD→TAKE when the counter reaches one.

The zero count is latched only in slots that take a sample. The enable bit is acted on only in those slots as well. A change therefore never cuts a padding run short.

Top module: `zpad_rate_adapter`

## Requirements
- R1: With the enable bit clear, every clock is a real slot. `out_real` is 1 and `out_data` equals the `in_data` presented one clock earlier.
- R2: A clock edge with `ctl_we` high loads the control word from `ctl_wdata`. Bit 4 is the enable and bits 3:0 are the zero count NZERO. The new word governs the sequencer from the following clock, and reset clears the word to 0.
- R3: With the enable bit set, the output repeats one real slot followed by exactly NZERO padding slots, so the period is NZERO+1 clocks. This holds for every NZERO from 0 to 15, and NZERO=0 gives a real slot on every clock.
- R4: In every padding slot `out_real` is 0 and `out_data` is all zeros.
- R5: A new NZERO written during a padding run does not change that run. It applies from the next real slot onward.
- R6: Clearing the enable bit during a padding run lets that run finish. The next slot is real, and pass-through follows from then on.
- R7: When padding is enabled from pass-through, the first clock in which the new word is visible is a real slot. The NZERO padding slots follow it.
- R8: While `rst_n` is low, `out_real` and `out_data` are 0 and the sequencer is in PASS.
- R9: With NZERO=15, exactly one slot in every 16 is real, which sets the minimum input rate at 1/16 of the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | Control word: bit 4 enable, bits 3:0 zero count |
| in_data | input | DATA_W | Input sample |
| out_data | output | DATA_W | Output sample, zero in padding slots |
| out_real | output | 1 | High in slots that carry a real input sample |

## Verification
The assertions take for granted that reset is held for at least one clock before any write. They also assume that `ctl_we` and `ctl_wdata` are stable around the clock edge. Apart from that they make no assumption about the input values, since the sequencer never looks at the data.

The stimulus drives every input on the falling edge and samples outputs there too. Every NZERO value is swept only after pass-through has been restored. Writes that fall in the middle of a run are placed at slot offsets chosen in advance, so the expected pattern follows by arithmetic from the requirements.

// File: rtl/zpad_pkg.sv
package zpad_pkg;

    localparam int ZP_CNT_W = 4;
    localparam int ZP_CTL_W = ZP_CNT_W + 1;

    typedef enum logic [1:0] {
        ST_PASS = 2'd0,
        ST_TAKE = 2'd1,
        ST_PAD  = 2'd2
    } zp_state_t;

    typedef struct packed {
        logic                en;
        logic [ZP_CNT_W-1:0] nzero;
    } zp_ctl_t;

endpackage

// File: rtl/zpad_ctl_reg.sv
module zpad_ctl_reg
    import zpad_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ZP_CTL_W-1:0] wdata,
    output zp_ctl_t             ctl
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (we) begin
            ctl <= zp_ctl_t'(wdata);
        end
    end

    a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (ctl == zp_ctl_t'($past(wdata))));

    a_r2_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && $past(rst_n)) |=> $stable(ctl));

endmodule

// File: rtl/zpad_sequencer.sv
module zpad_sequencer
    import zpad_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  zp_ctl_t   ctl,
    output logic      take,
    output zp_state_t state
);

    zp_state_t           state_nx;
    logic [ZP_CNT_W-1:0] cnt;
    logic [ZP_CNT_W-1:0] cnt_nx;

    // state and counter register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_PASS;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // next state and counter
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_PASS, ST_TAKE: begin
                cnt_nx = ctl.nzero;
                if (!ctl.en) begin
                    state_nx = ST_PASS;
                end else if (ctl.nzero == '0) begin
                    state_nx = ST_TAKE;
                end else begin
                    state_nx = ST_PAD;
                end
            end
            ST_PAD: begin
                cnt_nx = cnt - 1'b1;
                if (cnt == ZP_CNT_W'(1)) begin
                    state_nx = ST_TAKE;
                end
            end
            default: begin
                state_nx = ST_PASS;
                cnt_nx   = '0;
            end
        endcase
    end

    // output decode
    always_comb begin
        unique case (state)
            ST_PASS, ST_TAKE: take = 1'b1;
            ST_PAD:           take = 1'b0;
            default:          take = 1'b0;
        endcase
    end

    a_r3_pad_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAD) |-> (cnt != '0));

    a_r3_pad_end_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAD && cnt == ZP_CNT_W'(1)) |=> (state == ST_TAKE));

    a_r5_count_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAD && cnt != ZP_CNT_W'(1)) |=>
            (state == ST_PAD && cnt == ZP_CNT_W'($past(cnt) - 1'b1)));

    a_r6_disable_only_at_take: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAD) |=> (state != ST_PASS));

    a_r8_reset_state: assert property (@(posedge clk)
        !rst_n |=> (state == ST_PASS));

endmodule

// File: rtl/zpad_out_stage.sv
module zpad_out_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] in_data,
    output logic [DATA_W-1:0] out_data,
    output logic              out_real
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            out_real <= 1'b0;
        end else if (take) begin
            out_data <= in_data;
            out_real <= 1'b1;
        end else begin
            out_data <= '0;
            out_real <= 1'b0;
        end
    end

    a_r4_pad_is_zero: assert property (@(posedge clk)
        !out_real |-> (out_data == '0));

    a_r1_data_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (out_real && out_data == $past(in_data)));

endmodule

// File: rtl/zpad_rate_adapter.sv
module zpad_rate_adapter
    import zpad_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_we,
    input  logic [ZP_CTL_W-1:0] ctl_wdata,
    input  logic [DATA_W-1:0]   in_data,
    output logic [DATA_W-1:0]   out_data,
    output logic                out_real
);

    zp_ctl_t   ctl;
    logic      take;
    zp_state_t seq_state;

    zpad_ctl_reg u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .ctl   (ctl)
    );

    zpad_sequencer u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl   (ctl),
        .take  (take),
        .state (seq_state)
    );

    zpad_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .in_data  (in_data),
        .out_data (out_data),
        .out_real (out_real)
    );

    a_r1_pass_gives_real: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_PASS) |=> out_real);

    a_r3_zero_count_every_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_TAKE && ctl.en && ctl.nzero == '0) |=> out_real);

    a_r8_reset_outputs: assert property (@(posedge clk)
        !rst_n |=> (!out_real && out_data == '0));

endmodule

// File: tb/sim_zpad_rate_adapter.sv
module sim_zpad_rate_adapter;

    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ctl_we = 1'b0;
    logic [4:0]        ctl_wdata = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic [DATA_W-1:0] out_data;
    logic              out_real;

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;
    logic [DATA_W-1:0] seed = 16'h1357;

    always #4 clk = ~clk;

    zpad_rate_adapter #(.DATA_W(DATA_W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .in_data   (in_data),
        .out_data  (out_data),
        .out_real  (out_real)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired: actual cycle %0d expected < 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    // er: 1 real, 0 padding, 2 don't care. Called at a falling edge.
    task automatic tick(input int er, input string tag);
        logic [DATA_W-1:0] exp_d;
        @(negedge clk);
        if (er != 2) begin
            exp_d = (er == 1) ? in_data : '0;
            vectors = vectors + 1;
            if (out_real !== (er == 1) || out_data !== exp_d) begin
                errors = errors + 1;
                $display("FAIL %s: actual real=%0b data=%h expected real=%0b data=%h",
                         tag, out_real, out_data, (er == 1), exp_d);
            end
        end
        ctl_we = 1'b0;
        seed = {seed[14:0], seed[15] ^ seed[13] ^ seed[12] ^ seed[10]};
        in_data = seed | 16'h0001;
    endtask

    task automatic write_ctl(input logic en, input logic [3:0] n);
        ctl_we    = 1'b1;
        ctl_wdata = {en, n};
    endtask

    initial begin
        // R8: reset state
        @(negedge clk);
        @(negedge clk);
        vectors = vectors + 1;
        if (out_real !== 1'b0 || out_data !== '0) begin
            errors = errors + 1;
            $display("FAIL R8 reset: actual real=%0b data=%h expected real=0 data=0",
                     out_real, out_data);
        end
        rst_n = 1'b1;
        tick(2, "R8");

        // R1: pass-through after reset with the cleared control word
        for (int i = 0; i < 8; i++) tick(1, "R1 pass-through");

        // R3, R4, R7, R9, R2: sweep every zero count
        for (int n = 0; n < 16; n++) begin
            write_ctl(1'b0, 4'd0);
            for (int i = 0; i < 20; i++) tick(2, "settle");
            for (int i = 0; i < 3; i++) tick(1, "R1 pass-through");
            write_ctl(1'b1, 4'(n));
            tick(1, "R7 pre-enable slot");
            for (int k = 0; k < 3 * (n + 1); k++) begin
                tick((k % (n + 1) == 0) ? 1 : 0,
                     (n == 15) ? "R9 sixteenth-rate pattern" :
                     ((k % (n + 1) == 0) ? "R3 R7 R2 real slot" : "R4 padding slot"));
            end
        end

        // R5: zero count rewritten during a padding run
        write_ctl(1'b0, 4'd0);
        for (int i = 0; i < 20; i++) tick(2, "settle");
        write_ctl(1'b1, 4'd5);
        tick(1, "R5 pre-enable slot");
        for (int k = 0; k < 15; k++) begin
            tick((k == 0 || (k >= 6 && (k - 6) % 3 == 0)) ? 1 : 0, "R5 count change at boundary");
            if (k == 2) write_ctl(1'b1, 4'd2);
        end

        // R6: enable cleared during a padding run
        write_ctl(1'b0, 4'd0);
        for (int i = 0; i < 20; i++) tick(2, "settle");
        write_ctl(1'b1, 4'd4);
        tick(1, "R6 pre-enable slot");
        for (int k = 0; k < 11; k++) begin
            tick((k == 0 || k >= 5) ? 1 : 0, "R6 disable completes run");
            if (k == 1) write_ctl(1'b0, 4'd0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule